// File: doc/BRIEF.md
# Parallel Bus Write-Cycle Sequencer

This block produces write strobes for an 8080-style parallel display bus. A requester hands over an address (or command) value together with a data word through a valid/ready handshake. The block then drives the address pins, lowers the active-low chip select, pulses the active-low write strobe and releases both again. Each edge is placed by one of four programmable timing counts, measured in cycles of the internal clock.

The four counts cover four intervals. The first is the address-to-select setup. The second is the select-to-strobe setup. The third is the strobe low width. The fourth is the hold from strobe release to select release. A count of N always yields N+1 cycles, so a count of zero still gives one cycle. The counts are captured when a request is accepted. A host can therefore reprogram them while a cycle is on the bus without disturbing that cycle.

Top module: `i80_write_seq`

## Requirements
- R1: After reset `bus_cs_n` and `bus_we_n` are high (1), `req_ready` is high, and `bus_addr` and `bus_data` are zero.
- R2: On acceptance (`req_valid` and `req_ready` high at a clock edge) `bus_addr` takes the request address at that edge. `bus_cs_n` then stays high for `cfg_cs_setup`+1 cycles before going low.
- R3: `bus_we_n` goes low `cfg_wr_setup`+1 cycles after `bus_cs_n` goes low.
- R4: `bus_we_n` stays low for exactly `cfg_wr_active`+1 cycles.
- R5: After `bus_we_n` returns high, `bus_cs_n` stays low for `cfg_wr_hold`+1 more cycles and then returns high.
- R6: `bus_data` shows the request data in the first cycle of `bus_we_n` low and holds it unchanged until `bus_cs_n` returns high.
- R7: All four timing inputs (4 bits each) are sampled at acceptance. Changing them later has no effect on the cycle in progress.
- R8: `req_ready` is low from the cycle after acceptance until `bus_cs_n` is high again. Consecutive writes are separated by at least one cycle with `bus_cs_n` high.
- R9: `bus_addr` and `bus_data` keep their last values while the block is idle.
- R10: `bus_we_n` is never low while `bus_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, counts all phases |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | AW | Address or command value for the write |
| req_data | input | DW | Data word for the write |
| cfg_cs_setup | input | TW | Address-to-select setup count |
| cfg_wr_setup | input | TW | Select-to-strobe setup count |
| cfg_wr_active | input | TW | Strobe low width count |
| cfg_wr_hold | input | TW | Strobe-release-to-select-release count |
| bus_addr | output | AW | Address pins |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_data | output | DW | Data pins |

## Verification
A wrong phase state or a wrong down-count value shows up at the pins as a strobe or select edge in the wrong cycle. Within one phase of the fault, the measured interval lengths stop matching the counts captured at acceptance. A corrupt data latch becomes visible in the very first strobe-low cycle. A state that skips back to idle early makes `req_ready` rise while select is still low, or ends the hold interval short. The bench therefore measures every interval of every write cycle by cycle, alongside the pin values.

// File: rtl/i80_write_seq.sv
module i80_write_seq #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [TW-1:0] cfg_cs_setup,
  input  logic [TW-1:0] cfg_wr_setup,
  input  logic [TW-1:0] cfg_wr_active,
  input  logic [TW-1:0] cfg_wr_hold,
  output logic [AW-1:0] bus_addr,
  output logic          bus_cs_n,
  output logic          bus_we_n,
  output logic [DW-1:0] bus_data
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SEL, S_STRB, S_HOLD} phase_e;

  phase_e        st;
  logic [TW-1:0] cnt;
  logic [TW-1:0] t_sel, t_strb, t_hold;
  logic [DW-1:0] pend;
  logic          last;

  assign last      = (cnt == '0);
  assign req_ready = (st == S_IDLE);
  assign bus_cs_n  = (st == S_IDLE) || (st == S_ADDR);
  assign bus_we_n  = (st != S_STRB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      t_sel    <= '0;
      t_strb   <= '0;
      t_hold   <= '0;
      pend     <= '0;
      bus_addr <= '0;
      bus_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          bus_addr <= req_addr;
          pend     <= req_data;
          cnt      <= cfg_cs_setup;
          t_sel    <= cfg_wr_setup;
          t_strb   <= cfg_wr_active;
          t_hold   <= cfg_wr_hold;
          st       <= S_ADDR;
        end
        S_ADDR: if (last) begin
          cnt <= t_sel;
          st  <= S_SEL;
        end else cnt <= cnt - 1'b1;
        S_SEL: if (last) begin
          cnt      <= t_strb;
          bus_data <= pend;
          st       <= S_STRB;
        end else cnt <= cnt - 1'b1;
        S_STRB: if (last) begin
          cnt <= t_hold;
          st  <= S_HOLD;
        end else cnt <= cnt - 1'b1;
        S_HOLD: if (last) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  a_r10_strobe_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> !bus_cs_n);
  // R8
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && bus_cs_n));
  a_r8_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |=> bus_cs_n);
  // R2
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(bus_addr));
  // R6
  a_r6_data_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n) && $past(bus_we_n == 1'b0 || bus_data == bus_data) && bus_we_n && $past(!bus_we_n)) |-> $stable(bus_data));
  a_r6_data_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we_n && $past(!bus_we_n)) |-> $stable(bus_data));
  // R5
  a_r5_release_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> $past(bus_we_n));
  // R9
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && $past(req_ready) && $past(!req_valid)) |-> ($stable(bus_addr) && $stable(bus_data)));

endmodule

// File: tb/tb_i80_write_seq.sv
module tb_i80_write_seq;
  localparam int AW = 8, DW = 16, TW = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [TW-1:0] cs_s = '0, wr_s = '0, wr_a = '0, wr_h = '0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic bus_cs_n, bus_we_n;

  always #2 clk = ~clk;

  i80_write_seq #(.AW(AW), .DW(DW), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data),
    .cfg_cs_setup(cs_s), .cfg_wr_setup(wr_s), .cfg_wr_active(wr_a), .cfg_wr_hold(wr_h),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_data(bus_data));

  typedef struct packed {
    logic [AW-1:0] a; logic [DW-1:0] d;
    logic [TW-1:0] c, s, w, h;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int c, input int s, input int w, input int h, input bit scramble);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = a; req_data = d;
    cs_s = TW'(c); wr_s = TW'(s); wr_a = TW'(w); wr_h = TW'(h);
    e.a = a; e.d = d; e.c = TW'(c); e.s = TW'(s); e.w = TW'(w); e.h = TW'(h);
    q.push_back(e);
    @(negedge clk);
    req_valid = 0;
    req_addr = ~a; req_data = ~d;
    if (scramble) begin // R7: retime mid-cycle
      cs_s = ~TW'(c); wr_s = ~TW'(s); wr_a = ~TW'(w); wr_h = ~TW'(h);
    end
  endtask

  // monitor / scoreboard
  int p = 0, n0, n1, n2, n3, gap = 0;
  bit had = 0, rdy_bad, cs_bad, dat_bad;
  logic [AW-1:0] last_a;
  logic [DW-1:0] last_d;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        case (p)
          0: if (!req_ready) begin
               if (had) chk(gap >= 1, "R8 idle gap", gap, 1);
               p = 1; n0 = 1; rdy_bad = 0; cs_bad = 0; dat_bad = 0;
               if (!bus_cs_n) cs_bad = 1;
             end else begin
               if (had) begin
                 chk(bus_addr == last_a, "R9 addr hold", bus_addr, last_a);
                 chk(bus_data == last_d, "R9 data hold", bus_data, last_d);
               end
               if (bus_cs_n) gap++;
             end
          1: if (bus_cs_n) n0++; else begin p = 2; n1 = 1; end
          2: if (bus_we_n) n1++; else begin
               p = 3; n2 = 1;
               if (q.size() > 0 && bus_data != q[0].d) dat_bad = 1;
             end
          3: if (!bus_we_n) begin
               n2++;
               if (q.size() > 0 && bus_data != q[0].d) dat_bad = 1;
             end else begin p = 4; n3 = 1; end
          4: if (!bus_cs_n) begin
               n3++;
               if (q.size() > 0 && bus_data != q[0].d) dat_bad = 1;
             end else begin
               exp_t e;
               p = 0; gap = 1; had = 1;
               if (q.size() == 0) chk(0, "R8 unexpected cycle", 0, 1);
               else begin
                 e = q.pop_front();
                 chk(n0 == e.c + 1, "R2 addr-to-select", n0, e.c + 1);
                 chk(n1 == e.s + 1, "R3 select-to-strobe", n1, e.s + 1);
                 chk(n2 == e.w + 1, "R4 strobe width", n2, e.w + 1);
                 chk(n3 == e.h + 1, "R5 hold", n3, e.h + 1);
                 chk(bus_addr == e.a, "R2 addr value", bus_addr, e.a);
                 chk(!dat_bad, "R6 data value", bus_data, e.d);
                 chk(!rdy_bad, "R8 ready low while busy", 1, 0);
                 chk(!cs_bad, "R10 strobe inside select", 1, 0);
                 last_a = e.a; last_d = e.d;
               end
             end
          default: p = 0;
        endcase
        if (p >= 1 && p <= 4) begin
          if (req_ready) rdy_bad = 1;
          if (!bus_we_n && bus_cs_n) cs_bad = 1;
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_cs_n === 1'b1, "R1 cs_n reset", bus_cs_n, 1);
    chk(bus_we_n === 1'b1, "R1 we_n reset", bus_we_n, 1);
    chk(req_ready === 1'b1, "R1 ready reset", req_ready, 1);
    chk(bus_addr === '0 && bus_data === '0, "R1 addr/data reset", bus_addr, 0);
    rst_n = 1;
    write(8'h2A, 16'h1234, 0, 0, 1, 0, 0);
    write(8'h01, 16'hBEEF, 0, 0, 0, 0, 0);
    write(8'hFF, 16'h0F0F, 15, 15, 15, 15, 0);
    write(8'h5C, 16'hA5A5, 3, 1, 4, 2, 1);
    write(8'h77, 16'h0001, 0, 7, 0, 9, 1);
    write(8'h80, 16'hFFFF, 12, 0, 5, 0, 0);
    for (int i = 0; i < 6; i++)
      write(AW'(i * 37), DW'(i * 4099), i % 3, (i * 5) % 16, i, 15 - i, i[0]);
    repeat (10) @(negedge clk);
    while (q.size() != 0 || p != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(bus_addr == last_a, "R9 final addr", bus_addr, last_a);
    finish_run();
  end
endmodule